// File: doc/BRIEF.md
# Register-Started Block Copy Engine

This block copies a run of 16-bit words between an external main memory and one of two local memories: a code store and a data store. Software programs a small register file first: a 32-bit main-memory byte address as a high half and a low half, a local word address, and a control word that picks the local memory and the direction. The copy begins at the moment the byte count is written. No separate "go" bit exists.

A mask register that holds a nonzero value vetoes the start. While a copy runs, a busy flag in the control word reads as one, and the count register reads back the value that was written. When the copy finishes, busy clears, the count reads zero and a single-cycle completion pulse appears. A count above the legal limit, or a request to copy the code store out to main memory, does not start a copy. Either one sets a sticky error flag and produces the completion pulse.

The engine drives a synchronous-read port on the data store, a write port on the code store, and a request/acknowledge port toward main memory. Each acknowledge moves one word.

Top module: `blkdma_top`

## Requirements
- R1: After reset, every register reads zero, and no memory request or completion pulse is active.
- R2: The main-memory byte address is {high register, low register}. The first word uses exactly this address, and each later word uses the previous address plus 2. The address registers keep their programmed values after the copy.
- R3: The local word address register gives the first local word. Each later word uses the next local word address, and the address wraps modulo 2^LADDR_W.
- R4: Register offsets are: 0 main address high, 1 main address low, 2 local word address, 3 control, 4 byte count, 5 mask. A write to offset 4 while idle starts a copy of floor(count/2) words. If that number is zero, the completion pulse appears with no memory access.
- R5: If the mask register is nonzero when the count is written, no memory is accessed and no completion pulse appears. Afterwards the count reads zero and the error flag does not change.
- R6: Control bit 2 reads 1 from the cycle after the count write until the copy ends, and 0 afterwards. The count register reads the written value while busy and reads zero once the copy ends.
- R7: Control bit 0 selects the direction: 1 copies main memory into local memory, 0 copies local memory out to main memory. Control bit 1 selects the local memory: 1 is the code store, 0 is the data store. Only the selected local memory is accessed, and the data arrive unchanged.
- R8: Two cases are errors: a count above MAX_BYTES (0x4000), and control bits {1,0} = {1,0}. An error sets control bit 3, accesses no memory and gives the completion pulse on the next cycle. Bit 3 stays set until a control write with bit 3 = 1 clears it.
- R9: A main-memory request stays asserted, with a stable address and direction, until it is acknowledged. Each acknowledge moves exactly one word. A local write happens only in the cycle of an acknowledged main-memory read.
- R10: The completion pulse lasts one cycle. It appears in the cycle right after the acknowledge of the last word, and no memory request is active during it.
- R11: A write to the count register while a copy is in progress is ignored. It neither restarts the copy nor changes the count readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| mm_req | output | 1 | Main-memory word request |
| mm_we | output | 1 | 1 = write toward main memory, 0 = read from it |
| mm_addr | output | 32 | Main-memory byte address |
| mm_wdata | output | 16 | Word written to main memory |
| mm_rdata | input | 16 | Word read from main memory, valid with mm_ack |
| mm_ack | input | 1 | Main-memory acknowledge |
| imem_we | output | 1 | Code store write enable |
| imem_addr | output | LADDR_W | Code store word address |
| imem_wdata | output | 16 | Code store write data |
| dmem_re | output | 1 | Data store read enable (data valid next cycle) |
| dmem_we | output | 1 | Data store write enable |
| dmem_addr | output | LADDR_W | Data store word address |
| dmem_wdata | output | 16 | Data store write data |
| dmem_rdata | input | 16 | Data store read data |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The bench builds the block with LADDR_W = 6, so each local memory holds 64 words, and it keeps the default 0x4000-byte limit. With 64 words, a start address of 60 wraps the local address after four words. A sweep of every byte count from 0 to 21 therefore covers odd counts, empty copies and wraparound in all three legal modes, with acknowledge delays of 0 to 2 cycles. The limit is small enough to run in full: exactly 0x4000 bytes moves 8192 words, while 0x4001 and 0xFFFF are rejected.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  localparam int REG_W   = 16;
  localparam int WORDS_W = REG_W - 1;

  typedef enum logic [2:0] {
    RA_MHI = 3'd0,
    RA_MLO = 3'd1,
    RA_LOC = 3'd2,
    RA_CTL = 3'd3,
    RA_LEN = 3'd4,
    RA_MSK = 3'd5
  } reg_addr_e;

  localparam int CTL_DIR = 0;
  localparam int CTL_SEL = 1;
  localparam int CTL_BSY = 2;
  localparam int CTL_ERR = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LRD  = 3'd1,
    ST_LCAP = 3'd2,
    ST_MWR  = 3'd3,
    ST_MRD  = 3'd4
  } eng_state_e;

  typedef struct packed {
    logic [31:0]      maddr;
    logic [REG_W-1:0] laddr;
    logic             dir_in;
    logic             sel_imem;
  } xfer_cfg_t;

endpackage

// File: rtl/blkdma_rst_sync.sv
module blkdma_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/blkdma_launch.sv
module blkdma_launch
  import blkdma_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 32'h4000
) (
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               busy,
  input  logic               mask_nz,
  input  logic               dir_in,
  input  logic               sel_imem,
  output logic               start_ok,
  output logic               start_err,
  output logic               start_nop,
  output logic [WORDS_W-1:0] words
);
  logic len_wr;
  logic bad_len;
  logic bad_dir;
  logic bad;
  logic empty;

  always_comb begin
    len_wr    = reg_we && (reg_addr == RA_LEN) && !busy && !mask_nz;
    bad_len   = 32'(reg_wdata) > MAX_BYTES;
    bad_dir   = sel_imem && !dir_in;
    bad       = bad_len || bad_dir;
    words     = reg_wdata[REG_W-1:1];
    empty     = (words == '0);
    start_err = len_wr && bad;
    start_ok  = len_wr && !bad && !empty;
    start_nop = len_wr && (bad || empty);
  end
endmodule

// File: rtl/blkdma_regs.sv
module blkdma_regs
  import blkdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             busy,
  input  logic             fin,
  input  logic             start_ok,
  input  logic             start_err,
  output xfer_cfg_t        cfg,
  output logic             mask_nz
);
  logic [REG_W-1:0] mhi_q, mhi_d;
  logic [REG_W-1:0] mlo_q, mlo_d;
  logic [REG_W-1:0] loc_q, loc_d;
  logic [REG_W-1:0] len_q, len_d;
  logic [REG_W-1:0] msk_q, msk_d;
  logic             dir_q, dir_d;
  logic             sel_q, sel_d;
  logic             err_q, err_d;

  logic wr_mhi, wr_mlo, wr_loc, wr_ctl, wr_len, wr_msk;
  logic en_cfg, en_len, en_err;

  always_comb begin
    wr_mhi = reg_we && (reg_addr == RA_MHI);
    wr_mlo = reg_we && (reg_addr == RA_MLO);
    wr_loc = reg_we && (reg_addr == RA_LOC);
    wr_ctl = reg_we && (reg_addr == RA_CTL);
    wr_len = reg_we && (reg_addr == RA_LEN) && !busy;
    wr_msk = reg_we && (reg_addr == RA_MSK);

    mhi_d = wr_mhi ? reg_wdata : mhi_q;
    mlo_d = wr_mlo ? reg_wdata : mlo_q;
    loc_d = wr_loc ? reg_wdata : loc_q;
    msk_d = wr_msk ? reg_wdata : msk_q;
    dir_d = wr_ctl ? reg_wdata[CTL_DIR] : dir_q;
    sel_d = wr_ctl ? reg_wdata[CTL_SEL] : sel_q;
    en_cfg = wr_mhi | wr_mlo | wr_loc | wr_msk | wr_ctl;

    len_d  = len_q;
    en_len = 1'b0;
    if (wr_len) begin
      len_d  = start_ok ? reg_wdata : '0;
      en_len = 1'b1;
    end else if (fin) begin
      len_d  = '0;
      en_len = 1'b1;
    end

    err_d  = err_q;
    en_err = 1'b0;
    if (start_err) begin
      err_d  = 1'b1;
      en_err = 1'b1;
    end else if (wr_ctl && reg_wdata[CTL_ERR]) begin
      err_d  = 1'b0;
      en_err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mhi_q <= '0;
      mlo_q <= '0;
      loc_q <= '0;
      msk_q <= '0;
      dir_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (en_cfg) begin
      mhi_q <= mhi_d;
      mlo_q <= mlo_d;
      loc_q <= loc_d;
      msk_q <= msk_d;
      dir_q <= dir_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (en_len) len_q <= len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (en_err) err_q <= err_d;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_MHI: reg_rdata = mhi_q;
      RA_MLO: reg_rdata = mlo_q;
      RA_LOC: reg_rdata = loc_q;
      RA_CTL: begin
        reg_rdata[CTL_DIR] = dir_q;
        reg_rdata[CTL_SEL] = sel_q;
        reg_rdata[CTL_BSY] = busy;
        reg_rdata[CTL_ERR] = err_q;
      end
      RA_LEN: reg_rdata = len_q;
      RA_MSK: reg_rdata = msk_q;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    cfg.maddr    = {mhi_q, mlo_q};
    cfg.laddr    = loc_q;
    cfg.dir_in   = dir_q;
    cfg.sel_imem = sel_q;
    mask_nz      = (msk_q != '0);
  end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int LADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ok,
  input  logic               start_nop,
  input  logic [WORDS_W-1:0] words,
  input  xfer_cfg_t          cfg,
  output logic               busy,
  output logic               fin,
  output logic               done,
  output logic               mm_req,
  output logic               mm_we,
  output logic [31:0]        mm_addr,
  output logic [REG_W-1:0]   mm_wdata,
  input  logic [REG_W-1:0]   mm_rdata,
  input  logic               mm_ack,
  output logic               imem_we,
  output logic [LADDR_W-1:0] imem_addr,
  output logic [REG_W-1:0]   imem_wdata,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [LADDR_W-1:0] dmem_addr,
  output logic [REG_W-1:0]   dmem_wdata,
  input  logic [REG_W-1:0]   dmem_rdata
);
  eng_state_e         state_q, state_d;
  logic [31:0]        maddr_q, maddr_d;
  logic [LADDR_W-1:0] laddr_q, laddr_d;
  logic [WORDS_W-1:0] rem_q, rem_d;
  logic [REG_W-1:0]   buf_q;
  logic               sel_q, sel_d;
  logic               done_q;

  logic load;
  logic step;
  logic last;
  logic cnt_en;
  logic buf_en;

  assign last = (rem_q == WORDS_W'(1));

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    load    = 1'b0;
    step    = 1'b0;
    mm_req  = 1'b0;
    mm_we   = 1'b0;
    dmem_re = 1'b0;
    dmem_we = 1'b0;
    imem_we = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          load    = 1'b1;
          sel_d   = cfg.sel_imem;
          state_d = cfg.dir_in ? ST_MRD : ST_LRD;
        end
      end
      ST_LRD: begin
        dmem_re = 1'b1;
        state_d = ST_LCAP;
      end
      ST_LCAP: begin
        state_d = ST_MWR;
      end
      ST_MWR: begin
        mm_req = 1'b1;
        mm_we  = 1'b1;
        if (mm_ack) begin
          step    = 1'b1;
          state_d = last ? ST_IDLE : ST_LRD;
        end
      end
      ST_MRD: begin
        mm_req = 1'b1;
        if (mm_ack) begin
          step    = 1'b1;
          imem_we = sel_q;
          dmem_we = !sel_q;
          state_d = last ? ST_IDLE : ST_MRD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    maddr_d = maddr_q;
    laddr_d = laddr_q;
    rem_d   = rem_q;
    if (load) begin
      maddr_d = cfg.maddr;
      laddr_d = cfg.laddr[LADDR_W-1:0];
      rem_d   = words;
    end else if (step) begin
      maddr_d = maddr_q + 32'd2;
      laddr_d = laddr_q + LADDR_W'(1);
      rem_d   = rem_q - WORDS_W'(1);
    end
    cnt_en = load | step;
    buf_en = (state_q == ST_LCAP);
    fin    = step && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      done_q  <= fin | start_nop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr_q <= '0;
      laddr_q <= '0;
      rem_q   <= '0;
    end else if (cnt_en) begin
      maddr_q <= maddr_d;
      laddr_q <= laddr_d;
      rem_q   <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= dmem_rdata;
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign mm_addr    = maddr_q;
  assign mm_wdata   = buf_q;
  assign imem_addr  = laddr_q;
  assign dmem_addr  = laddr_q;
  assign imem_wdata = mm_rdata;
  assign dmem_wdata = mm_rdata;
endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
  import blkdma_pkg::*;
#(
  parameter int          LADDR_W   = 12,
  parameter int unsigned MAX_BYTES = 32'h4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic               mm_req,
  output logic               mm_we,
  output logic [31:0]        mm_addr,
  output logic [15:0]        mm_wdata,
  input  logic [15:0]        mm_rdata,
  input  logic               mm_ack,
  output logic               imem_we,
  output logic [LADDR_W-1:0] imem_addr,
  output logic [15:0]        imem_wdata,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [LADDR_W-1:0] dmem_addr,
  output logic [15:0]        dmem_wdata,
  input  logic [15:0]        dmem_rdata,
  output logic               done
);
  logic               rst_s;
  logic               busy;
  logic               fin;
  logic               start_ok;
  logic               start_err;
  logic               start_nop;
  logic               mask_nz;
  logic [WORDS_W-1:0] words;
  xfer_cfg_t          cfg;

  blkdma_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  blkdma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .fin       (fin),
    .start_ok  (start_ok),
    .start_err (start_err),
    .cfg       (cfg),
    .mask_nz   (mask_nz)
  );

  blkdma_launch #(.MAX_BYTES(MAX_BYTES)) u_launch (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .mask_nz   (mask_nz),
    .dir_in    (cfg.dir_in),
    .sel_imem  (cfg.sel_imem),
    .start_ok  (start_ok),
    .start_err (start_err),
    .start_nop (start_nop),
    .words     (words)
  );

  blkdma_engine #(.LADDR_W(LADDR_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_s),
    .start_ok   (start_ok),
    .start_nop  (start_nop),
    .words      (words),
    .cfg        (cfg),
    .busy       (busy),
    .fin        (fin),
    .done       (done),
    .mm_req     (mm_req),
    .mm_we      (mm_we),
    .mm_addr    (mm_addr),
    .mm_wdata   (mm_wdata),
    .mm_rdata   (mm_rdata),
    .mm_ack     (mm_ack),
    .imem_we    (imem_we),
    .imem_addr  (imem_addr),
    .imem_wdata (imem_wdata),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mm_req,
  input logic        mm_we,
  input logic [31:0] mm_addr,
  input logic        mm_ack,
  input logic        imem_we,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic        done
);
  logic        have_prev;
  logic [31:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (done) begin
      have_prev <= 1'b0;
    end else if (mm_req && mm_ack) begin
      have_prev <= 1'b1;
      prev_addr <= mm_addr;
    end
  end

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && have_prev) |-> (mm_addr == prev_addr + 32'd2));

  p_one_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_we, dmem_we, dmem_re}));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && !mm_ack) |=> (mm_req && $stable(mm_addr) && $stable(mm_we)));

  p_wr_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_we || dmem_we) |-> (mm_req && mm_ack && !mm_we));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mm_req && !dmem_re));
endmodule

bind blkdma_top blkdma_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mm_req  (mm_req),
  .mm_we   (mm_we),
  .mm_addr (mm_addr),
  .mm_ack  (mm_ack),
  .imem_we (imem_we),
  .dmem_we (dmem_we),
  .dmem_re (dmem_re),
  .done    (done)
);

// File: tb/sim_blkdma_top.sv
`timescale 1ns/1ps
module sim_blkdma_top;
  localparam int LW = 6;
  localparam int LN = 1 << LW;
  localparam int MN = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [15:0]   reg_wdata = 16'd0;
  logic [15:0]   reg_rdata;
  logic          mm_req, mm_we, mm_ack;
  logic [31:0]   mm_addr;
  logic [15:0]   mm_wdata, mm_rdata;
  logic          imem_we, dmem_re, dmem_we, done;
  logic [LW-1:0] imem_addr, dmem_addr;
  logic [15:0]   imem_wdata, dmem_wdata;
  logic [15:0]   dmem_rdata;

  logic [15:0] mmem [MN];
  logic [15:0] dmem [LN];
  logic [15:0] imem [LN];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int cyc = 0;
  int ack_dly = 0;
  int wcnt = 0;
  int ack_cnt = 0;
  int addr_bad = 0;
  int done_cnt = 0;
  int done_cyc = 0;
  int last_ack_cyc = 0;
  int init_id = 0;
  int init_seen = 0;
  int init_seed = 0;
  int arm_id = 0;
  int arm_seen = 0;
  logic [31:0] arm_addr = '0;
  logic [31:0] exp_addr = '0;

  always #10 clk = ~clk;

  blkdma_top #(.LADDR_W(LW), .MAX_BYTES(32'h4000)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mm_req(mm_req),
    .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .mm_ack(mm_ack), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata), .dmem_re(dmem_re),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .done(done)
  );

  function automatic logic [15:0] mpat(int i, int s);
    return 16'(i * 40503 + s * 977 + 7);
  endfunction
  function automatic logic [15:0] dpat(int j, int s);
    return 16'(j * 2579 + s * 131 + 1234);
  endfunction
  function automatic logic [15:0] ipat(int j, int s);
    return 16'(j * 7919 + s * 53 + 99);
  endfunction

  assign mm_ack   = mm_req && (wcnt >= ack_dly);
  assign mm_rdata = mmem[mm_addr[8:1]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (init_seen != init_id) begin
      init_seen <= init_id;
      for (int i = 0; i < MN; i++) mmem[i] <= mpat(i, init_seed);
      for (int j = 0; j < LN; j++) begin
        dmem[j] <= dpat(j, init_seed);
        imem[j] <= ipat(j, init_seed);
      end
    end else begin
      if (dmem_re) dmem_rdata <= dmem[dmem_addr];
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      if (imem_we) imem[imem_addr] <= imem_wdata;
      if (mm_req && mm_ack && mm_we) mmem[mm_addr[8:1]] <= mm_wdata;
    end
    if (mm_req && !mm_ack) wcnt <= wcnt + 1;
    else                   wcnt <= 0;
    if (mm_req && mm_ack) begin
      ack_cnt      <= ack_cnt + 1;
      last_ack_cyc <= cyc;
      if (arm_seen != arm_id) begin
        arm_seen <= arm_id;
        if (mm_addr !== arm_addr) addr_bad <= addr_bad + 1;
        exp_addr <= arm_addr + 32'd2;
      end else begin
        if (mm_addr !== exp_addr) addr_bad <= addr_bad + 1;
        exp_addr <= exp_addr + 32'd2;
      end
    end
    if (done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_done(input int d0, input int limit);
    for (int n = 0; n < limit && done_cnt == d0; n++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input bit din, input bit sim, input logic [31:0] ma,
                      input logic [15:0] la, input logic [15:0] len, input int dly,
                      input int seed, input bit exp_err);
    int words, a0, b0, d0, mi, li;
    bit legal;
    logic [15:0] v, got, expv;
    words = int'(len) / 2;
    legal = (len <= 16'h4000) && !(sim && !din);
    ack_dly = dly; init_seed = seed; init_id++;
    @(negedge clk);
    wr(3'd0, ma[31:16]);
    wr(3'd1, ma[15:0]);
    wr(3'd2, la);
    wr(3'd3, {14'd0, sim, din});
    arm_addr = ma; arm_id++;
    a0 = ack_cnt; b0 = addr_bad; d0 = done_cnt;
    wr(3'd4, len);
    if (legal && words > 0) begin
      rd_now(3'd3, v);
      chk(v[2] == 1'b1, "R6 busy while running", v[2], 1);
      rd_now(3'd4, v);
      chk(v == len, "R6 count readback while busy", v, len);
    end
    wait_done(d0, 40000);
    chk(done_cnt - d0 == 1, "R4/R10 one completion pulse", done_cnt - d0, 1);
    chk(ack_cnt - a0 == (legal ? words : 0), "R4/R9 words moved",
        ack_cnt - a0, legal ? words : 0);
    chk(addr_bad == b0, "R2 main address sequence", addr_bad - b0, 0);
    if (legal && words > 0)
      chk(done_cyc == last_ack_cyc + 1, "R10 pulse after last word", done_cyc, last_ack_cyc + 1);
    rd_now(3'd3, v);
    chk(v[2] == 1'b0, "R6 busy cleared", v[2], 0);
    chk(v[3] == exp_err, "R8 error flag", v[3], exp_err);
    chk(v[1:0] == {sim, din}, "R7 control readback", v[1:0], {sim, din});
    rd_now(3'd4, v);
    chk(v == 16'd0, "R6 count reads zero after", v, 0);
    rd_now(3'd0, v);
    chk(v == ma[31:16], "R2 high address kept", v, ma[31:16]);
    rd_now(3'd1, v);
    chk(v == ma[15:0], "R2 low address kept", v, ma[15:0]);
    if (legal && words <= LN) begin
      for (int k = 0; k < words; k++) begin
        li = (int'(la) + k) % LN;
        mi = (int'(ma[15:0]) / 2 + k) % MN;
        if (din) begin
          got  = sim ? imem[li] : dmem[li];
          expv = mpat(mi, seed);
          chk(got == expv, "R3/R7 local word copied in", got, expv);
          got  = sim ? dmem[li] : imem[li];
          expv = sim ? dpat(li, seed) : ipat(li, seed);
          chk(got == expv, "R7 other local memory untouched", got, expv);
        end else begin
          got  = mmem[mi];
          expv = dpat(li, seed);
          chk(got == expv, "R3/R7 word copied out", got, expv);
        end
      end
      if (words < LN) begin
        li = (int'(la) + words) % LN;
        mi = (int'(ma[15:0]) / 2 + words) % MN;
        if (din) begin
          got  = sim ? imem[li] : dmem[li];
          expv = sim ? ipat(li, seed) : dpat(li, seed);
        end else begin
          got  = mmem[mi];
          expv = mpat(mi, seed);
        end
        chk(got == expv, "R4 word past end untouched", got, expv);
      end
    end
    if (!legal) begin
      li = int'(la) % LN;
      chk(dmem[li] == dpat(li, seed), "R8 no local access on error", dmem[li], dpat(li, seed));
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int a0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd_now(3'(a), v);
      chk(v == 16'd0, "R1 register reset value", v, 0);
    end
    chk(!mm_req && !done && !dmem_re, "R1 idle outputs", {mm_req, done, dmem_re}, 0);

    // R2 R3 R4 R7 R9 R10: sweep of counts in every legal mode
    for (int len = 0; len < 22; len++) begin
      xfer(1'b1, 1'b0, 32'h0003_0040, (len % 2) ? 16'd60 : 16'd0, 16'(len), len % 3, len, 1'b0);
      xfer(1'b1, 1'b1, 32'h0012_0100, 16'd60, 16'(len), (len + 1) % 3, len + 50, 1'b0);
      xfer(1'b0, 1'b0, 32'hA5A5_01F0, (len % 2) ? 16'd3 : 16'd60, 16'(len), (len + 2) % 3, len + 90, 1'b0);
    end

    // R4: exact limit is legal
    xfer(1'b1, 1'b0, 32'h0001_0000, 16'd0, 16'h4000, 0, 7, 1'b0);

    // R8: count over limit, unsupported direction, sticky and clear
    xfer(1'b1, 1'b0, 32'h0001_0000, 16'd5, 16'h4001, 0, 8, 1'b1);
    xfer(1'b1, 1'b0, 32'h0001_0000, 16'd5, 16'h0006, 1, 9, 1'b1);
    wr(3'd3, 16'h0008);
    rd_now(3'd3, v);
    chk(v[3] == 1'b0, "R8 error cleared by write-one", v[3], 0);
    xfer(1'b0, 1'b1, 32'h0001_0000, 16'd5, 16'h0008, 0, 10, 1'b1);
    wr(3'd3, 16'h0008);
    xfer(1'b1, 1'b0, 32'h0001_0000, 16'd5, 16'hFFFF, 0, 11, 1'b1);
    wr(3'd3, 16'h0008);

    // R5: mask vetoes the start
    wr(3'd5, 16'h0100);
    wr(3'd3, 16'h0001);
    a0 = ack_cnt; d0 = done_cnt;
    wr(3'd4, 16'd8);
    repeat (20) @(negedge clk);
    chk(ack_cnt == a0, "R5 masked start moves nothing", ack_cnt - a0, 0);
    chk(done_cnt == d0, "R5 masked start gives no pulse", done_cnt - d0, 0);
    rd_now(3'd4, v);
    chk(v == 16'd0, "R5 count reads zero after masked start", v, 0);
    rd_now(3'd3, v);
    chk(v[3:2] == 2'b00, "R5 no busy and no error", v[3:2], 0);
    wr(3'd5, 16'h0000);

    // R11: count write during a copy is ignored
    ack_dly = 2;
    wr(3'd3, 16'h0001);
    arm_addr = 32'h0; arm_id++;
    wr(3'd0, 16'h0); wr(3'd1, 16'h0); wr(3'd2, 16'h0);
    arm_id++;
    a0 = ack_cnt; d0 = done_cnt;
    wr(3'd4, 16'd8);
    wr(3'd4, 16'd40);
    rd_now(3'd4, v);
    chk(v == 16'd8, "R11 count unchanged by write while busy", v, 8);
    wait_done(d0, 2000);
    repeat (20) @(negedge clk);
    chk(ack_cnt - a0 == 4, "R11 word count from first write only", ack_cnt - a0, 4);
    chk(done_cnt - d0 == 1, "R11 single completion", done_cnt - d0, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule